// File: doc/BRIEF.md
# Flash Operation Sequencer with Nested Suspend

This block sequences program, erase and lock-bit operations for a byte-wide flash array of sixteen equal erase blocks. It accepts requests that a bus front end has already decoded, decides whether each is allowed from the per-block lock bits, a master lock bit, a programming-supply lockout input and a three-level reset input, and then runs a timed busy phase. A ready/busy output and sticky status flags report the outcome. The cells are represented by a behavioural array in which erased bytes read as all ones and programming can only clear bits.

A block erase may be paused so that reads can proceed or so that a byte in another block can be written. That write may itself be paused for reads, which gives two levels of suspension. Each paused operation keeps its remaining cycle count, so a resume continues from where it stopped. An elevated reset level overrides the block locks and is the only level at which the master lock can be set, or block locks changed once the master lock is set.

Top module: `nvm_op_sequencer`

## Requirements
- R1: Request codes on `req_op` are 0 byte write, 1 block erase, 2 set block lock, 3 clear block lock, 4 set master lock, 5 suspend, 6 resume, 7 clear status. `rp_level` encodes 0 low, 1 normal, 2 override (3 acts as normal). After reset, `ready` is 1, every flag and lock is 0, and every byte reads 0xFF.
- R2: An accepted byte write holds `ready` low for WRITE_CYC cycles. The byte then reads as old AND data. The block is `addr[19:16]` and the byte within the modelled block is `addr[3:0]`.
- R3: An accepted block erase holds `ready` low for ERASE_CYC cycles. Every byte of that block then reads 0xFF, and other blocks are unchanged.
- R4: Set and clear block lock change only the addressed block's bit in `blk_locks`, and set master lock sets `master_lock`. Each holds `ready` low for LOCK_CYC cycles. Setting the master lock needs the override level. While the master lock is set, changing a block lock also needs the override level.
- R5: A write or erase aimed at a locked block is refused unless `rp_level` is at the override level, in which case it proceeds.
- R6: While `vpp_low` is 1, every write, erase and lock request is refused and the array and lock bits stay unchanged.
- R7: A refused request never lowers `ready`. It sets `err_prot` together with `err_write` for a write, or with `err_erase` for an erase or lock request. These flags stay set until a clear-status request.
- R8: A suspend during a running erase takes effect at the next clock: `ready` goes high, `erase_held` is set, and resume continues the remaining count. While the erase is held, a write to another block runs. A write to the held block, and any erase or lock request, is ignored.
- R9: A suspend during a running write sets `write_held` and raises `ready`. While a write is held, only resume and clear status act. Resume restarts the held write before the held erase.
- R10: A suspend with nothing running, or a resume with nothing held, changes no output.
- R11: A suspend that arrives in an operation's final busy cycle is ignored. The operation completes and nothing is left held.
- R12: With `rp_level` low, the running operation is aborted without touching the array, held operations and error flags are cleared, `pwr_down` is 1, `ready` is 1, and requests are ignored. On release the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Request code (R1) |
| req_addr | input | ADDR_W | Byte address of the request; upper four bits select the block |
| req_data | input | DW | Write data |
| rp_level | input | 2 | Reset level: low, normal or override |
| vpp_low | input | 1 | Programming supply at or below lockout |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DW | Read data, one cycle after `rd_addr` |
| ready | output | 1 | High when nothing is executing |
| pwr_down | output | 1 | Power-down state |
| err_prot | output | 1 | Sticky protection error |
| err_erase | output | 1 | Sticky erase or lock error |
| err_write | output | 1 | Sticky write error |
| erase_held | output | 1 | An erase is suspended |
| write_held | output | 1 | A write is suspended |
| blk_locks | output | NBLK | Per-block lock bits |
| master_lock | output | 1 | Master lock bit |

## Verification
Two events can land on the same clock edge: the completion of a busy phase and a suspend request. The bench places a suspend on exactly the edge where a byte write's count expires. It then expects the write to be complete, no write held, `ready` high and the new byte readable, and a following resume to have no effect. A second concurrency point is the nested case. There the bench checks exact remaining busy lengths after each resume, which shows that suspension stopped the count on the very edge it was accepted.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    OP_WRITE      = 3'd0,
    OP_ERASE      = 3'd1,
    OP_LOCK_SET   = 3'd2,
    OP_LOCK_CLR   = 3'd3,
    OP_MASTER_SET = 3'd4,
    OP_SUSPEND    = 3'd5,
    OP_RESUME     = 3'd6,
    OP_CLR_STAT   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RP_LOW  = 2'd0,
    RP_NORM = 2'd1,
    RP_OVR  = 2'd2,
    RP_RSVD = 2'd3
  } rp_e;

  typedef enum logic [1:0] {
    LK_SET    = 2'd0,
    LK_CLR    = 2'd1,
    LK_MASTER = 2'd2
  } lk_e;

endpackage

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_seq_pkg::*;
(
  input  op_e  op,
  input  rp_e  rp,
  input  logic vpp_low,
  input  logic blk_locked,
  input  logic master,
  output logic deny
);

  logic ovr;
  assign ovr = (rp == RP_OVR);

  always_comb begin
    deny = 1'b0;
    case (op)
      OP_WRITE, OP_ERASE:        deny = vpp_low || (blk_locked && !ovr);
      OP_LOCK_SET, OP_LOCK_CLR:  deny = vpp_low || (master && !ovr);
      OP_MASTER_SET:             deny = vpp_low || !ovr;
      default:                   deny = 1'b0;
    endcase
  end

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt != '0));

endmodule

// File: rtl/nvm_array_model.sv
module nvm_array_model #(
  parameter int ADDR_W    = 20,
  parameter int DW        = 8,
  parameter int NBLK      = 16,
  parameter int BLK_DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic [ADDR_W-1:0]        pg_addr,
  output logic [DW-1:0]            pg_old,
  input  logic                     pg_we,
  input  logic [DW-1:0]            pg_wdata,
  input  logic                     er_we,
  input  logic [$clog2(NBLK)-1:0]  er_blk
);

  localparam int BLK_W = $clog2(NBLK);
  localparam int OFF_W = $clog2(BLK_DEPTH);
  localparam int IDX_W = BLK_W + OFF_W;
  localparam int DEPTH = NBLK * BLK_DEPTH;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] prog_map;
  logic [IDX_W-1:0] rd_idx, pg_idx;
  logic [DW-1:0]    rd_q, pg_q;
  logic             rd_v, pg_v;

  assign rd_idx = {rd_addr[ADDR_W-1 -: BLK_W], rd_addr[OFF_W-1:0]};
  assign pg_idx = {pg_addr[ADDR_W-1 -: BLK_W], pg_addr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (pg_we) mem[pg_idx] <= pg_wdata;
    rd_q <= mem[rd_idx];
    pg_q <= mem[pg_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_map <= '0;
      rd_v     <= 1'b0;
      pg_v     <= 1'b0;
    end else begin
      if (er_we) prog_map[{er_blk, {OFF_W{1'b0}}} +: BLK_DEPTH] <= '0;
      if (pg_we) prog_map[pg_idx] <= 1'b1;
      rd_v <= prog_map[rd_idx];
      pg_v <= prog_map[pg_idx];
    end
  end

  assign rd_data = rd_v ? rd_q : {DW{1'b1}};
  assign pg_old  = pg_v ? pg_q : {DW{1'b1}};

  // R3
  pg_er_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pg_we && er_we));

endmodule

// File: rtl/nvm_op_sequencer.sv
module nvm_op_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DW        = 8,
  parameter int NBLK      = 16,
  parameter int BLK_DEPTH = 16,
  parameter int CNT_W     = 16,
  parameter int ERASE_CYC = 40,
  parameter int WRITE_CYC = 12,
  parameter int LOCK_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [1:0]        rp_level,
  input  logic              vpp_low,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              ready,
  output logic              pwr_down,
  output logic              err_prot,
  output logic              err_erase,
  output logic              err_write,
  output logic              erase_held,
  output logic              write_held,
  output logic [NBLK-1:0]   blk_locks,
  output logic              master_lock
);

  localparam int BLK_W = $clog2(NBLK);

  op_e op;
  rp_e rp;
  assign op = op_e'(req_op);
  assign rp = rp_e'(rp_level);

  // state
  logic              e_run, e_susp, w_run, w_susp, l_run;
  logic [BLK_W-1:0]  e_blk, l_blk;
  logic [ADDR_W-1:0] w_addr;
  logic [DW-1:0]     w_data;
  lk_e               l_kind;
  logic [NBLK-1:0]   locks;
  logic              master;
  logic              f_prot, f_erase, f_write, pd_q, ready_q;

  // decode
  logic [BLK_W-1:0]  req_blk;
  logic rp_low, any_run, idle_all, e_only_held;
  logic e_last, w_last, e_done, w_done, l_done;
  logic deny, ctx_ok, take, start, refuse;
  logic sus_e, sus_w, res_e, res_w, clr, live;
  logic is_lock_op;
  logic e_load, w_load, e_tick, w_tick;
  logic [CNT_W-1:0] w_len;
  logic n_e_run, n_e_susp, n_w_run, n_w_susp, n_l_run;
  logic [DW-1:0] pg_old;
  logic pg_we, er_we;

  assign req_blk     = req_addr[ADDR_W-1 -: BLK_W];
  assign rp_low      = (rp == RP_LOW);
  assign live        = req_valid && !rp_low;
  assign any_run     = e_run | w_run | l_run;
  assign idle_all    = !any_run && !e_susp && !w_susp;
  assign e_only_held = e_susp && !w_susp && !any_run;
  assign e_done      = e_run && e_last;
  assign w_done      = w_run && w_last;
  assign l_done      = l_run && w_last;
  assign is_lock_op  = (op == OP_LOCK_SET) || (op == OP_LOCK_CLR) || (op == OP_MASTER_SET);

  nvm_guard u_guard (
    .op         (op),
    .rp         (rp),
    .vpp_low    (vpp_low),
    .blk_locked (locks[req_blk]),
    .master     (master),
    .deny       (deny)
  );

  always_comb begin
    case (op)
      OP_WRITE:                    ctx_ok = idle_all || (e_only_held && req_blk != e_blk);
      OP_ERASE, OP_LOCK_SET,
      OP_LOCK_CLR, OP_MASTER_SET:  ctx_ok = idle_all;
      default:                     ctx_ok = 1'b0;
    endcase
  end

  assign take   = live && ctx_ok;
  assign start  = take && !deny;
  assign refuse = take && deny;
  assign sus_e  = live && (op == OP_SUSPEND) && e_run && !e_last;
  assign sus_w  = live && (op == OP_SUSPEND) && w_run && !w_last;
  assign res_w  = live && (op == OP_RESUME) && w_susp;
  assign res_e  = live && (op == OP_RESUME) && e_only_held;
  assign clr    = live && (op == OP_CLR_STAT);

  // next-state of the run/hold flags
  always_comb begin
    n_e_run  = e_run;
    n_e_susp = e_susp;
    n_w_run  = w_run;
    n_w_susp = w_susp;
    n_l_run  = l_run;
    if (e_done || sus_e)                n_e_run  = 1'b0;
    if (start && op == OP_ERASE || res_e) n_e_run = 1'b1;
    if (sus_e)                          n_e_susp = 1'b1;
    if (res_e)                          n_e_susp = 1'b0;
    if (w_done || sus_w)                n_w_run  = 1'b0;
    if (start && op == OP_WRITE || res_w) n_w_run = 1'b1;
    if (sus_w)                          n_w_susp = 1'b1;
    if (res_w)                          n_w_susp = 1'b0;
    if (l_done)                         n_l_run  = 1'b0;
    if (start && is_lock_op)            n_l_run  = 1'b1;
    if (rp_low) begin
      n_e_run = 1'b0; n_e_susp = 1'b0;
      n_w_run = 1'b0; n_w_susp = 1'b0;
      n_l_run = 1'b0;
    end
  end

  // timers: one for erase, one shared by write and lock operations
  assign e_load = start && (op == OP_ERASE);
  assign w_load = start && (op != OP_ERASE);
  assign w_len  = (op == OP_WRITE) ? CNT_W'(WRITE_CYC) : CNT_W'(LOCK_CYC);
  assign e_tick = e_run && !sus_e && !rp_low;
  assign w_tick = (w_run || l_run) && !sus_w && !rp_low;

  nvm_op_timer #(.CNT_W(CNT_W)) u_erase_tmr (
    .clk(clk), .rst(rst), .load(e_load), .load_val(CNT_W'(ERASE_CYC)),
    .tick(e_tick), .last(e_last)
  );

  nvm_op_timer #(.CNT_W(CNT_W)) u_prog_tmr (
    .clk(clk), .rst(rst), .load(w_load), .load_val(w_len),
    .tick(w_tick), .last(w_last)
  );

  assign pg_we = w_done && !rp_low;
  assign er_we = e_done && !rp_low;

  nvm_array_model #(
    .ADDR_W(ADDR_W), .DW(DW), .NBLK(NBLK), .BLK_DEPTH(BLK_DEPTH)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pg_addr  (w_addr),
    .pg_old   (pg_old),
    .pg_we    (pg_we),
    .pg_wdata (pg_old & w_data),
    .er_we    (er_we),
    .er_blk   (e_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      e_run   <= 1'b0; e_susp <= 1'b0; e_blk  <= '0;
      w_run   <= 1'b0; w_susp <= 1'b0; w_addr <= '0; w_data <= '0;
      l_run   <= 1'b0; l_kind <= LK_SET; l_blk <= '0;
      locks   <= '0;   master <= 1'b0;
      f_prot  <= 1'b0; f_erase <= 1'b0; f_write <= 1'b0;
      pd_q    <= 1'b0; ready_q <= 1'b1;
    end else begin
      e_run  <= n_e_run;  e_susp <= n_e_susp;
      w_run  <= n_w_run;  w_susp <= n_w_susp;
      l_run  <= n_l_run;
      pd_q   <= rp_low;
      ready_q <= !(n_e_run || n_w_run || n_l_run);
      if (e_load) e_blk <= req_blk;
      if (start && op == OP_WRITE) begin
        w_addr <= req_addr;
        w_data <= req_data;
      end
      if (start && is_lock_op) begin
        l_blk <= req_blk;
        case (op)
          OP_LOCK_SET: l_kind <= LK_SET;
          OP_LOCK_CLR: l_kind <= LK_CLR;
          default:     l_kind <= LK_MASTER;
        endcase
      end
      if (l_done && !rp_low) begin
        case (l_kind)
          LK_SET:  locks[l_blk] <= 1'b1;
          LK_CLR:  locks[l_blk] <= 1'b0;
          default: master       <= 1'b1;
        endcase
      end
      if (rp_low || clr) begin
        f_prot <= 1'b0; f_erase <= 1'b0; f_write <= 1'b0;
      end else if (refuse) begin
        f_prot <= 1'b1;
        if (op == OP_WRITE) f_write <= 1'b1;
        else                f_erase <= 1'b1;
      end
    end
  end

  assign ready       = ready_q;
  assign pwr_down    = pd_q;
  assign err_prot    = f_prot;
  assign err_erase   = f_erase;
  assign err_write   = f_write;
  assign erase_held  = e_susp;
  assign write_held  = w_susp;
  assign blk_locks   = locks;
  assign master_lock = master;

  // R8
  busy_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({e_run, w_run, l_run}));

  // R8
  erase_sus_chk: assert property (@(posedge clk) disable iff (rst)
    sus_e |=> (erase_held && ready));

  // R9
  write_held_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    write_held |-> ready);

  // R7
  refuse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd0 && vpp_low && rp_level == 2'd1 && ready
     && !erase_held && !write_held) |=> (ready && err_prot && err_write));

  // R7
  prot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_prot && !(req_valid && req_op == 3'd7) && rp_level != 2'd0) |=> err_prot);

  // R10
  idle_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == 3'd5 || req_op == 3'd6) && ready && !erase_held
     && !write_held && rp_level != 2'd0) |=> (ready && !erase_held && !write_held));

  // R12
  pd_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_level == 2'd0) |=> (pwr_down && ready && !erase_held && !write_held));

endmodule

// File: tb/sim_nvm_op_sequencer.sv
module sim_nvm_op_sequencer;
  import nvm_seq_pkg::*;

  localparam int ERASE_CYC = 40;
  localparam int WRITE_CYC = 12;
  localparam int LOCK_CYC  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [1:0]  rp_level = 2'd1;
  logic        vpp_low = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        ready, pwr_down, err_prot, err_erase, err_write;
  logic        erase_held, write_held, master_lock;
  logic [15:0] blk_locks;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvm_op_sequencer #(
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .LOCK_CYC(LOCK_CYC)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rp_level(rp_level),
    .vpp_low(vpp_low), .rd_addr(rd_addr), .rd_data(rd_data),
    .ready(ready), .pwr_down(pwr_down), .err_prot(err_prot),
    .err_erase(err_erase), .err_write(err_write), .erase_held(erase_held),
    .write_held(write_held), .blk_locks(blk_locks), .master_lock(master_lock)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input op_e op, input logic [19:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic flags_zero(input string tag);
    check({tag, " err_prot"},  err_prot, 0);
    check({tag, " err_erase"}, err_erase, 0);
    check({tag, " err_write"}, err_write, 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 ready", ready, 1);
    check("R1 pwr_down", pwr_down, 0);
    flags_zero("R1");
    check("R1 held", {erase_held, write_held}, 0);
    check("R1 locks", blk_locks, 0);
    check("R1 master", master_lock, 0);
    rd(20'h00000, d); check("R1 blank lo", d, 8'hFF);
    rd(20'hF000F, d); check("R1 blank hi", d, 8'hFF);
  endtask

  task automatic t_write;
    int n; logic [7:0] d;
    issue(OP_WRITE, 20'h12345, 8'h5A);
    busy_len(n); check("R2 busy len", n, WRITE_CYC);
    rd(20'h12345, d); check("R2 data", d, 8'h5A);
    issue(OP_WRITE, 20'h12345, 8'h0F);
    busy_len(n);
    rd(20'h12345, d); check("R2 and-merge", d, 8'h0A);
    rd(20'h12346, d); check("R2 neighbour", d, 8'hFF);
  endtask

  task automatic t_erase;
    int n; logic [7:0] d;
    issue(OP_WRITE, 20'h20003, 8'h11); busy_len(n);
    issue(OP_ERASE, 20'h10000, 8'h00);
    busy_len(n); check("R3 busy len", n, ERASE_CYC);
    rd(20'h12345, d); check("R3 erased", d, 8'hFF);
    rd(20'h20003, d); check("R3 other block", d, 8'h11);
  endtask

  task automatic t_lock;
    int n; logic [7:0] d;
    issue(OP_LOCK_SET, 20'h30000, 8'h00);
    busy_len(n); check("R4 lock busy", n, LOCK_CYC);
    check("R4 lock bit", blk_locks, 16'h0008);
    issue(OP_WRITE, 20'h30002, 8'h00);
    check("R5 refused ready", ready, 1);
    check("R7 prot", err_prot, 1);
    check("R7 write err", err_write, 1);
    check("R7 erase err", err_erase, 0);
    repeat (3) @(negedge clk);
    check("R7 sticky", err_prot, 1);
    rd(20'h30002, d); check("R5 untouched", d, 8'hFF);
    issue(OP_CLR_STAT, 20'h0, 8'h0); flags_zero("R7 clr");
    issue(OP_ERASE, 20'h30000, 8'h00);
    check("R5 erase refused ready", ready, 1);
    check("R7 erase err", err_erase, 1);
    issue(OP_CLR_STAT, 20'h0, 8'h0);
    rp_level = 2'd2;
    issue(OP_WRITE, 20'h30002, 8'h44);
    busy_len(n); check("R5 override busy", n, WRITE_CYC);
    rp_level = 2'd1;
    rd(20'h30002, d); check("R5 override data", d, 8'h44);
  endtask

  task automatic t_vpp;
    int n; logic [7:0] d;
    vpp_low = 1'b1;
    issue(OP_WRITE, 20'h40001, 8'h00);
    check("R6 ready", ready, 1);
    check("R6 write err", err_write, 1);
    issue(OP_LOCK_SET, 20'h40000, 8'h00);
    check("R6 lock ready", ready, 1);
    check("R6 erase err", err_erase, 1);
    vpp_low = 1'b0;
    @(negedge clk);
    check("R6 locks", blk_locks, 16'h0008);
    rd(20'h40001, d); check("R6 data", d, 8'hFF);
    issue(OP_CLR_STAT, 20'h0, 8'h0);
    busy_len(n);
  endtask

  task automatic t_master;
    int n;
    issue(OP_MASTER_SET, 20'h0, 8'h0);
    check("R4 master normal", master_lock, 0);
    check("R4 master prot", err_prot, 1);
    issue(OP_CLR_STAT, 20'h0, 8'h0);
    rp_level = 2'd2;
    issue(OP_MASTER_SET, 20'h0, 8'h0);
    busy_len(n); check("R4 master busy", n, LOCK_CYC);
    check("R4 master set", master_lock, 1);
    rp_level = 2'd1;
    issue(OP_LOCK_CLR, 20'h30000, 8'h0);
    check("R4 clr refused", err_prot, 1);
    check("R4 locks kept", blk_locks, 16'h0008);
    issue(OP_CLR_STAT, 20'h0, 8'h0);
    rp_level = 2'd2;
    issue(OP_LOCK_CLR, 20'h30000, 8'h0);
    busy_len(n);
    rp_level = 2'd1;
    check("R4 lock cleared", blk_locks, 16'h0000);
  endtask

  task automatic t_nested;
    int n; logic [7:0] d;
    issue(OP_WRITE, 20'h50007, 8'h00); busy_len(n);
    issue(OP_ERASE, 20'h50000, 8'h00);
    repeat (5) @(negedge clk);
    issue(OP_SUSPEND, 20'h0, 8'h0);
    check("R8 ready", ready, 1);
    check("R8 erase_held", erase_held, 1);
    issue(OP_WRITE, 20'h50007, 8'h00);
    check("R8 same-block ignored", ready, 1);
    check("R8 no flag", err_prot, 0);
    issue(OP_WRITE, 20'h60004, 8'h33);
    check("R8 write runs", ready, 0);
    repeat (3) @(negedge clk);
    issue(OP_SUSPEND, 20'h0, 8'h0);
    check("R9 write_held", write_held, 1);
    check("R9 ready", ready, 1);
    issue(OP_ERASE, 20'h70000, 8'h00);
    check("R9 erase ignored", ready, 1);
    issue(OP_RESUME, 20'h0, 8'h0);
    check("R9 write first", write_held, 0);
    check("R9 erase still held", erase_held, 1);
    busy_len(n); check("R9 write remaining", n, WRITE_CYC - 3);
    rd(20'h60004, d); check("R9 write data", d, 8'h33);
    issue(OP_RESUME, 20'h0, 8'h0);
    check("R8 resumed", erase_held, 0);
    busy_len(n); check("R8 erase remaining", n, ERASE_CYC - 5);
    rd(20'h50007, d); check("R8 erase result", d, 8'hFF);
  endtask

  task automatic t_idle;
    issue(OP_SUSPEND, 20'h0, 8'h0);
    check("R10 suspend idle", {ready, erase_held, write_held}, 3'b100);
    issue(OP_RESUME, 20'h0, 8'h0);
    check("R10 resume idle", {ready, erase_held, write_held}, 3'b100);
    flags_zero("R10");
  endtask

  task automatic t_race;
    logic [7:0] d;
    issue(OP_WRITE, 20'h80002, 8'h21);
    repeat (WRITE_CYC - 1) @(negedge clk);
    issue(OP_SUSPEND, 20'h0, 8'h0);
    check("R11 ready", ready, 1);
    check("R11 not held", write_held, 0);
    rd(20'h80002, d); check("R11 data", d, 8'h21);
    issue(OP_RESUME, 20'h0, 8'h0);
    check("R11 resume no-op", ready, 1);
  endtask

  task automatic t_pd;
    int n; logic [7:0] d;
    issue(OP_ERASE, 20'h20000, 8'h00);
    repeat (4) @(negedge clk);
    rp_level = 2'd0;
    @(negedge clk);
    check("R12 pwr_down", pwr_down, 1);
    check("R12 ready", ready, 1);
    issue(OP_WRITE, 20'h90000, 8'h00);
    check("R12 ignored", ready, 1);
    rp_level = 2'd1;
    @(negedge clk);
    check("R12 released", pwr_down, 0);
    check("R12 idle", {ready, erase_held}, 2'b10);
    rd(20'h20003, d); check("R12 aborted erase", d, 8'h11);
    rd(20'h90000, d); check("R12 no write", d, 8'hFF);
    issue(OP_WRITE, 20'h90000, 8'h7E);
    busy_len(n); check("R12 write after", n, WRITE_CYC);
    rd(20'h90000, d); check("R12 data after", d, 8'h7E);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_erase();
    t_lock();
    t_vpp();
    t_master();
    t_nested();
    t_idle();
    t_race();
    t_pd();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule